// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned integer by another over a fixed number of clock cycles, producing one quotient bit per cycle. A one-cycle start request loads the operands; the unit then works through the dividend from its most significant bit downwards. On each cycle it moves the next dividend bit into a running partial remainder and tries to take the divisor away from it. The sign of that trial difference decides the new quotient bit, and the partial remainder is updated only when the difference is not negative.

The unit is meant to sit beside an integer datapath as a long-latency functional unit. The caller raises the start input for one cycle with both operands valid. It then watches busy, or waits for the single-cycle done pulse, and reads the quotient and remainder. These results stay on the outputs until the next accepted start. The operand width is a parameter with a default of 32 bits. The latency is always exactly that many cycles, including when the divisor is zero.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted and after its release, busy_o and done_o are 0 and quotient_o and remainder_o are all zeros.
- R2: A start_i sampled high while busy_o is 0 is accepted: in the next cycle busy_o is 1 and quotient_o and remainder_o are both zero.
- R3: In each busy cycle, the partial remainder is shifted left by one with the current top dividend bit entering at bit 0. If this value is greater than or equal to the divisor, the divisor is subtracted and a 1 is shifted into quotient bit 0. Otherwise a 0 is shifted in and the shifted value is kept. The dividend then shifts left with 0 entering at bit 0. quotient_o and remainder_o show the registers after every step.
- R4: busy_o stays high for exactly W cycles per accepted start. done_o is high for exactly one cycle, the first cycle with busy_o low after those W cycles.
- R5: While busy_o is 0 and no start is accepted, quotient_o and remainder_o hold their values.
- R6: A start_i sampled while busy_o is 1 has no effect on the running division or its result.
- R7: For a nonzero divisor, the final quotient is the floor of dividend/divisor and the remainder is dividend mod divisor (e.g. 29 / 3 gives quotient 9, remainder 2).
- R8: For a zero divisor, the final quotient is all ones and the remainder equals the dividend, after the same W busy cycles.
- R9: A dividend smaller than the divisor gives quotient 0 with the dividend as remainder; a divisor of 1 gives the dividend as quotient and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| dividend_i | input | W | Dividend operand, captured on accepted start |
| divisor_i | input | W | Divisor operand, captured on accepted start |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle pulse after the final iteration |
| quotient_o | output | W | Quotient register (partial while busy) |
| remainder_o | output | W | Remainder register (partial while busy) |

## Verification
The quotient and remainder registers are visible on every cycle, so a bad compare, a wrong shift or a misrouted dividend bit shows up at the ports on the very cycle it happens. It is not hidden until the final result. A step counter that is off by one appears as busy_o falling, or done_o pulsing, one cycle early or late, relative to a reference stepped alongside the design. A start that wrongly restarts a running division clears the outputs on the next cycle, and the reference catches that at once.

// File: rtl/div_pkg.sv
package div_pkg;

    // Phase of the iteration sequencer.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } div_phase_e;

endpackage

// File: rtl/div_step.sv
// One restoring iteration: shift the next dividend bit into the partial
// remainder, trial-subtract the divisor and pick the quotient bit from the
// sign of the difference.
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] dvd_o,
    output logic [W-1:0] quo_o
);
    localparam int SW = W + 1;   // shifted remainder width
    localparam int DW = W + 2;   // trial difference width, top bit is sign

    logic [SW-1:0] shifted;
    logic [DW-1:0] trial;
    logic          fits;
    logic          unused_bits;

    always_comb begin
        shifted     = {rem_i, dvd_i[W-1]};
        trial       = {1'b0, shifted} - {2'b00, dvs_i};
        fits        = ~trial[DW-1];
        rem_o       = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_o       = {quo_i[W-2:0], fits};
        dvd_o       = {dvd_i[W-2:0], 1'b0};
        unused_bits = trial[W] ^ shifted[W] ^ quo_i[W-1];
    end

endmodule

// File: rtl/div_ctrl.sv
// Iteration sequencer: accepts a start while idle, counts W steps, then
// raises the completion pulse for one cycle.
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        div_phase_e    phase;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load_o     = 1'b0;
        step_o     = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load_o      = 1'b1;
                    ctl_d.phase = PH_RUN;
                    ctl_d.cnt   = '0;
                end
            end
            PH_RUN: begin
                step_o = 1'b1;
                if (ctl_q.cnt == LAST) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.cnt   = '0;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = (ctl_q.phase == PH_RUN);
    assign done_o = ctl_q.done;

endmodule

// File: rtl/restoring_divider.sv
// Multi-cycle unsigned restoring divider, one quotient bit per cycle.
module restoring_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o
);
    typedef struct packed {
        logic [W-1:0] rem;
        logic [W-1:0] dvd;
        logic [W-1:0] quo;
        logic [W-1:0] dvs;
    } dp_t;

    dp_t dp_d, dp_q;

    logic         load;
    logic         step;
    logic [W-1:0] nxt_rem;
    logic [W-1:0] nxt_dvd;
    logic [W-1:0] nxt_quo;

    div_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    div_step #(.W(W)) u_step (
        .rem_i (dp_q.rem),
        .dvd_i (dp_q.dvd),
        .quo_i (dp_q.quo),
        .dvs_i (dp_q.dvs),
        .rem_o (nxt_rem),
        .dvd_o (nxt_dvd),
        .quo_o (nxt_quo)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.rem = '0;
            dp_d.quo = '0;
            dp_d.dvd = dividend_i;
            dp_d.dvs = divisor_i;
        end else if (step) begin
            dp_d.rem = nxt_rem;
            dp_d.quo = nxt_quo;
            dp_d.dvd = nxt_dvd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign quotient_o  = dp_q.quo;
    assign remainder_o = dp_q.rem;

endmodule

// File: rtl/div_checker.sv
// Port-level properties of the divider, bound to every instance.
module div_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o
);
    logic [W-1:0] cap_dvd;
    logic [W-1:0] cap_dvs;
    int unsigned  busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_dvd  <= '0;
            cap_dvs  <= '0;
            busy_run <= 0;
        end else begin
            if (start_i && !busy_o) begin
                cap_dvd <= dividend_i;
                cap_dvs <= divisor_i;
            end
            busy_run <= busy_o ? busy_run + 1 : 0;
        end
    end

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && quotient_o == '0 && remainder_o == '0));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_run == W && !busy_o));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));

    p_busy_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_run < W - 1) |=> busy_o);

    p_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_dvs != '0) |->
            (quotient_o == cap_dvd / cap_dvs && remainder_o == cap_dvd % cap_dvs));

    p_zero_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_dvs == '0) |-> (quotient_o == '1 && remainder_o == cap_dvd));

endmodule

bind restoring_divider div_checker #(.W(W)) u_div_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
);

// File: tb/tb_restoring_divider.sv
`timescale 1ns/1ps
module tb_restoring_divider;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] quotient_o, remainder_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    restoring_divider #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o),
        .quotient_o(quotient_o), .remainder_o(remainder_o)
    );

    // Behavioural reference, advanced at every rising edge.
    bit              m_busy, m_done, m_fresh;
    int              m_cnt;
    longint unsigned m_q, m_r, m_d, m_s;
    logic [W-1:0]    cap_dvd, cap_dvs;
    longint unsigned mask;

    initial mask = (64'd1 << W) - 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_fresh = 0; m_cnt = 0;
            m_q = 0; m_r = 0; m_d = 0; m_s = 0;
        end else begin
            m_done  = 0;
            m_fresh = 0;
            if (m_busy) begin
                m_r = (m_r * 2) + ((m_d >> (W - 1)) & 1);
                m_d = (m_d * 2) & mask;
                if (m_r >= m_s) begin
                    m_r = m_r - m_s;
                    m_q = ((m_q * 2) + 1) & mask;
                end else begin
                    m_q = (m_q * 2) & mask;
                end
                m_cnt++;
                if (m_cnt == W) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start_i) begin
                m_q = 0; m_r = 0; m_cnt = 0;
                m_d = dividend_i; m_s = divisor_i;
                cap_dvd = dividend_i; cap_dvs = divisor_i;
                m_busy = 1; m_fresh = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            string tq;
            if (!rst_n)        tq = "R1";
            else if (m_fresh)  tq = "R2";
            else if (m_busy)   tq = "R3";
            else               tq = "R5";
            check(busy_o == m_busy, m_busy ? "R4" : "R4", "busy", busy_o, m_busy);
            check(done_o == m_done, "R4", "done", done_o, m_done);
            check(quotient_o == m_q[W-1:0], tq, "quotient", quotient_o, m_q);
            check(remainder_o == m_r[W-1:0], tq, "remainder", remainder_o, m_r);
            if (rst_n && done_o) begin
                if (cap_dvs == '0) begin
                    check(quotient_o == '1, "R8", "zero-divisor quotient", quotient_o, mask);
                    check(remainder_o == cap_dvd, "R8", "zero-divisor remainder", remainder_o, cap_dvd);
                end else begin
                    string tr;
                    tr = (cap_dvd < cap_dvs || cap_dvs == 1) ? "R9" : "R7";
                    check(quotient_o == cap_dvd / cap_dvs, tr, "final quotient",
                          quotient_o, cap_dvd / cap_dvs);
                    check(remainder_o == cap_dvd % cap_dvs, tr, "final remainder",
                          remainder_o, cap_dvd % cap_dvs);
                end
            end
        end
    end

    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        start_i = 1'b1; dividend_i = a; divisor_i = b;
        @(negedge clk);
        start_i = 1'b0; dividend_i = '0; divisor_i = '0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b);
        launch(a, b);
        wait_done();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports after release
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && quotient_o == '0 && remainder_o == '0,
              "R1", "post-reset outputs", {busy_o, done_o}, 0);

        run(32'd29, 32'd3);                       // R7 worked example
        run(32'hDEADBEEF, 32'h0001_2345);         // R7
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF);        // R7
        run(32'h8000_0000, 32'd2);                // R7
        run(32'd5, 32'd7);                        // R9 small dividend
        run(32'd0, 32'd9);                        // R9
        run(32'hCAFE_F00D, 32'd1);                // R9 divisor of one
        run(32'd123, 32'd0);                      // R8 zero divisor
        run(32'hFFFF_FFFF, 32'd0);                // R8

        // R6: start pulses while busy must not disturb the division
        launch(32'd1000, 32'd7);
        repeat (5) @(negedge clk);
        start_i = 1'b1; dividend_i = 32'd1; divisor_i = 32'd1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        start_i = 1'b1; dividend_i = 32'hFFFF; divisor_i = 32'd0;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check(quotient_o == 32'd142 && remainder_o == 32'd6, "R6",
              "result after ignored starts", quotient_o, 142);

        // R5: outputs hold over a long idle gap
        repeat (20) @(negedge clk);
        check(quotient_o == 32'd142 && remainder_o == 32'd6, "R5",
              "held result", remainder_o, 6);

        // R2: back-to-back start in the done cycle
        launch(32'd77, 32'd10);
        wait_done();
        start_i = 1'b1; dividend_i = 32'd100; divisor_i = 32'd33;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && quotient_o == '0, "R2", "start in done cycle", busy_o, 1);
        wait_done();
        repeat (2) @(negedge clk);

        // Mixed operands
        for (int i = 0; i < 12; i++) begin
            logic [W-1:0] a, b;
            a = $urandom();
            b = $urandom() >> (i * 2);
            run(a, b);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule